// File: doc/BRIEF.md
# Instruction Fetch Micro Translation Cache

This block is a tiny, fully associative translation cache on the instruction fetch path. It sits in front of a slower full translator. Each accepted lookup carries a virtual fetch address, the current address-space identifier and a flag that marks the instruction as a control transfer (branch, jump or exception return). It holds two entries, and each entry maps one 4 KB page. An entry is tagged with a virtual page number, an address-space identifier and a global bit.

On a hit, the block returns the physical address one cycle after the lookup is accepted. On a miss, it raises a walk request to the full translator and drops its ready output. It then waits for the translator's acknowledge, writes the result into the entry chosen by a one-bit least-recently-used pointer, and returns the physical address. With that response it reports how many fetch stall cycles the miss costs. A synchronous flush invalidates both entries.

Top module: `fetch_utlb`

## Requirements
- R1: After synchronous reset, `rdy_o` is 1 and `resp_valid_o`, `walk_req_o` and `resp_stall_o` are 0. Both entries are invalid, and the LRU pointer selects entry 0.
- R2: A lookup accepted at a clock edge (`req_valid_i` and `rdy_o` both 1) that hits produces, after that edge, `resp_valid_o`=1, `resp_hit_o`=1 and `resp_stall_o`=0. In the same response, `resp_paddr_o` is the entry's physical page number in bits [PA_W-1:12] and the fetch address bits [11:0] below it.
- R3: A valid entry hits only when its page number equals fetch address bits [VA_W-1:12] and either its global bit is 1 or its stored identifier equals `req_asid_i`.
- R4: A hit on entry 0 points the LRU pointer at entry 1, and a hit on entry 1 points it at entry 0.
- R5: A miss raises `walk_req_o` after the accepting edge, with `walk_vpn_o` and `walk_asid_o` taken from the lookup. `walk_req_o` stays 1 with stable fields and `rdy_o` stays 0 until the edge where `walk_ack_i` is 1. Lookups offered while busy are ignored and produce no response.
- R6: At the acknowledge edge, the entry selected by the LRU pointer is loaded with the page number, the identifier, `walk_global_i` and `walk_ppn_i`, and is marked valid. The LRU pointer then flips.
- R7: After the acknowledge edge, the block gives `resp_valid_o`=1, `resp_hit_o`=0 and `rdy_o`=1. In that response, `resp_paddr_o` is `walk_ppn_i` with the fetch offset below it. `resp_stall_o` is 1 when the lookup had `req_short_i`=1 and 2 otherwise.
- R8: `flush_i` clears both valid bits at the edge. A lookup accepted at the same edge as the flush misses, and a fill at that edge leaves its entry invalid.
- R9: When both entries match, entry 0 supplies the physical address and the LRU pointer moves to entry 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Invalidate both entries |
| req_valid_i | input | 1 | Lookup request |
| req_vaddr_i | input | VA_W | Virtual fetch address |
| req_asid_i | input | ASID_W | Current address-space identifier |
| req_short_i | input | 1 | 1 for branch, jump or exception return |
| rdy_o | output | 1 | Ready to accept a lookup |
| resp_valid_o | output | 1 | Response strobe, one cycle |
| resp_hit_o | output | 1 | Response came from a stored entry |
| resp_paddr_o | output | PA_W | Translated physical address |
| resp_stall_o | output | 2 | Stall cycles charged (0, 1 or 2) |
| walk_req_o | output | 1 | Full translation request |
| walk_vpn_o | output | VA_W-12 | Page number to translate |
| walk_asid_o | output | ASID_W | Identifier to translate under |
| walk_ack_i | input | 1 | Translator result valid |
| walk_ppn_i | input | PA_W-12 | Physical page number from the translator |
| walk_global_i | input | 1 | Translated page ignores the identifier |

## Verification
A hit response is registered, so it is visible during the cycle after the edge that accepts the lookup. A miss shows its walk request in that same cycle instead. The miss response appears in the cycle after the edge where the acknowledge is high. The bench drives inputs on falling edges and samples at the next falling edge, so every result is read exactly half a period after the edge that produced it. A two-entry reference table with an LRU bit predicts hit or miss, the address and the stall count. That prediction also covers busy cycles with offered requests, flushes and random acknowledge latency.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  localparam int unsigned PAGE_W      = 12;
  localparam int unsigned ENTRIES     = 2;
  localparam int unsigned STALL_W     = 2;
  localparam logic [STALL_W-1:0] STALL_SHORT = 2'd1;
  localparam logic [STALL_W-1:0] STALL_LONG  = 2'd2;
endpackage

// File: rtl/utlb_tags.sv
module utlb_tags
  import utlb_pkg::*;
#(
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned PPN_W  = 20,
  parameter int unsigned ASID_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush_i,
  input  logic [VPN_W-1:0]     look_vpn_i,
  input  logic [ASID_W-1:0]    look_asid_i,
  input  logic                 wr_en_i,
  input  logic                 wr_idx_i,
  input  logic [VPN_W-1:0]     wr_vpn_i,
  input  logic [ASID_W-1:0]    wr_asid_i,
  input  logic                 wr_glob_i,
  input  logic [PPN_W-1:0]     wr_ppn_i,
  output logic [ENTRIES-1:0]   match_o,
  output logic [PPN_W-1:0]     match_ppn_o
);
  logic [ENTRIES*PPN_W-1:0] ppn_flat;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic              vld_q;
    logic              glob_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;
    logic [PPN_W-1:0]  ppn_q;
    logic              sel;

    assign sel = wr_en_i && (wr_idx_i == e[0]);

    always_ff @(posedge clk) begin
      if (rst || flush_i) begin
        vld_q <= 1'b0;
      end else if (sel) begin
        vld_q <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        vpn_q  <= wr_vpn_i;
        asid_q <= wr_asid_i;
        glob_q <= wr_glob_i;
        ppn_q  <= wr_ppn_i;
      end
    end

    assign match_o[e] = vld_q && (vpn_q == look_vpn_i) &&
                        (glob_q || (asid_q == look_asid_i));
    assign ppn_flat[e*PPN_W +: PPN_W] = ppn_q;
  end

  // lowest index wins when several entries match
  always_comb begin
    match_ppn_o = ppn_flat[(ENTRIES-1)*PPN_W +: PPN_W];
    for (int i = ENTRIES - 2; i >= 0; i--) begin
      if (match_o[i]) match_ppn_o = ppn_flat[i*PPN_W +: PPN_W];
    end
  end
endmodule

// File: rtl/utlb_ctrl.sv
module utlb_ctrl
  import utlb_pkg::*;
#(
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned PPN_W  = 20,
  parameter int unsigned ASID_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush_i,
  input  logic                 req_valid_i,
  input  logic [VPN_W-1:0]     req_vpn_i,
  input  logic [PAGE_W-1:0]    req_off_i,
  input  logic [ASID_W-1:0]    req_asid_i,
  input  logic                 req_short_i,
  input  logic [ENTRIES-1:0]   match_i,
  input  logic [PPN_W-1:0]     match_ppn_i,
  input  logic                 walk_ack_i,
  input  logic [PPN_W-1:0]     walk_ppn_i,
  input  logic                 walk_global_i,
  output logic                 rdy_o,
  output logic                 walk_req_o,
  output logic [VPN_W-1:0]     walk_vpn_o,
  output logic [ASID_W-1:0]    walk_asid_o,
  output logic                 wr_en_o,
  output logic                 wr_idx_o,
  output logic [VPN_W-1:0]     wr_vpn_o,
  output logic [ASID_W-1:0]    wr_asid_o,
  output logic                 wr_glob_o,
  output logic [PPN_W-1:0]     wr_ppn_o,
  output logic                 resp_valid_o,
  output logic                 resp_hit_o,
  output logic [PPN_W+PAGE_W-1:0] resp_paddr_o,
  output logic [STALL_W-1:0]   resp_stall_o
);
  logic              busy_q, lru_q, short_q;
  logic [VPN_W-1:0]  pvpn_q;
  logic [ASID_W-1:0] pasid_q;
  logic [PAGE_W-1:0] poff_q;
  logic              accept, hit, done;

  assign accept = req_valid_i && !busy_q;
  assign hit    = (|match_i) && !flush_i;
  assign done   = busy_q && walk_ack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q       <= 1'b0;
      lru_q        <= 1'b0;
      short_q      <= 1'b0;
      pvpn_q       <= '0;
      pasid_q      <= '0;
      poff_q       <= '0;
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_paddr_o <= '0;
      resp_stall_o <= '0;
    end else begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      if (accept && hit) begin
        resp_valid_o <= 1'b1;
        resp_hit_o   <= 1'b1;
        resp_paddr_o <= {match_ppn_i, req_off_i};
        resp_stall_o <= '0;
        lru_q        <= match_i[0];
      end else if (accept) begin
        busy_q  <= 1'b1;
        pvpn_q  <= req_vpn_i;
        pasid_q <= req_asid_i;
        poff_q  <= req_off_i;
        short_q <= req_short_i;
      end else if (done) begin
        busy_q       <= 1'b0;
        resp_valid_o <= 1'b1;
        resp_paddr_o <= {walk_ppn_i, poff_q};
        resp_stall_o <= short_q ? STALL_SHORT : STALL_LONG;
        lru_q        <= ~lru_q;
      end
    end
  end

  assign rdy_o       = !busy_q;
  assign walk_req_o  = busy_q;
  assign walk_vpn_o  = pvpn_q;
  assign walk_asid_o = pasid_q;
  assign wr_en_o     = done;
  assign wr_idx_o    = lru_q;
  assign wr_vpn_o    = pvpn_q;
  assign wr_asid_o   = pasid_q;
  assign wr_glob_o   = walk_global_i;
  assign wr_ppn_o    = walk_ppn_i;
endmodule

// File: rtl/fetch_utlb.sv
module fetch_utlb
  import utlb_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned ASID_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush_i,
  input  logic                 req_valid_i,
  input  logic [VA_W-1:0]      req_vaddr_i,
  input  logic [ASID_W-1:0]    req_asid_i,
  input  logic                 req_short_i,
  output logic                 rdy_o,
  output logic                 resp_valid_o,
  output logic                 resp_hit_o,
  output logic [PA_W-1:0]      resp_paddr_o,
  output logic [STALL_W-1:0]   resp_stall_o,
  output logic                 walk_req_o,
  output logic [VA_W-13:0]     walk_vpn_o,
  output logic [ASID_W-1:0]    walk_asid_o,
  input  logic                 walk_ack_i,
  input  logic [PA_W-13:0]     walk_ppn_i,
  input  logic                 walk_global_i
);
  localparam int unsigned VPN_W = VA_W - PAGE_W;
  localparam int unsigned PPN_W = PA_W - PAGE_W;

  logic [ENTRIES-1:0] match;
  logic [PPN_W-1:0]   match_ppn;
  logic               wr_en, wr_idx, wr_glob;
  logic [VPN_W-1:0]   wr_vpn;
  logic [ASID_W-1:0]  wr_asid;
  logic [PPN_W-1:0]   wr_ppn;

  utlb_tags #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)) tags_i (
    .clk         (clk),
    .rst         (rst),
    .flush_i     (flush_i),
    .look_vpn_i  (req_vaddr_i[VA_W-1:PAGE_W]),
    .look_asid_i (req_asid_i),
    .wr_en_i     (wr_en),
    .wr_idx_i    (wr_idx),
    .wr_vpn_i    (wr_vpn),
    .wr_asid_i   (wr_asid),
    .wr_glob_i   (wr_glob),
    .wr_ppn_i    (wr_ppn),
    .match_o     (match),
    .match_ppn_o (match_ppn)
  );

  utlb_ctrl #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)) ctrl_i (
    .clk           (clk),
    .rst           (rst),
    .flush_i       (flush_i),
    .req_valid_i   (req_valid_i),
    .req_vpn_i     (req_vaddr_i[VA_W-1:PAGE_W]),
    .req_off_i     (req_vaddr_i[PAGE_W-1:0]),
    .req_asid_i    (req_asid_i),
    .req_short_i   (req_short_i),
    .match_i       (match),
    .match_ppn_i   (match_ppn),
    .walk_ack_i    (walk_ack_i),
    .walk_ppn_i    (walk_ppn_i),
    .walk_global_i (walk_global_i),
    .rdy_o         (rdy_o),
    .walk_req_o    (walk_req_o),
    .walk_vpn_o    (walk_vpn_o),
    .walk_asid_o   (walk_asid_o),
    .wr_en_o       (wr_en),
    .wr_idx_o      (wr_idx),
    .wr_vpn_o      (wr_vpn),
    .wr_asid_o     (wr_asid),
    .wr_glob_o     (wr_glob),
    .wr_ppn_o      (wr_ppn),
    .resp_valid_o  (resp_valid_o),
    .resp_hit_o    (resp_hit_o),
    .resp_paddr_o  (resp_paddr_o),
    .resp_stall_o  (resp_stall_o)
  );
endmodule

// File: rtl/fetch_utlb_chk.sv
module fetch_utlb_chk #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned ASID_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              flush_i,
  input logic              req_valid_i,
  input logic              rdy_o,
  input logic              walk_req_o,
  input logic              walk_ack_i,
  input logic [VA_W-13:0]  walk_vpn_o,
  input logic [ASID_W-1:0] walk_asid_o,
  input logic              resp_valid_o,
  input logic              resp_hit_o,
  input logic [1:0]        resp_stall_o
);
  a_r5_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    walk_req_o |-> !rdy_o);

  a_r5_walk_holds: assert property (@(posedge clk) disable iff (rst)
    (walk_req_o && !walk_ack_i) |=> (walk_req_o && $stable(walk_vpn_o) && $stable(walk_asid_o)));

  a_r2_accept_answers: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && rdy_o) |=> (resp_valid_o || walk_req_o));

  a_r7_ack_completes: assert property (@(posedge clk) disable iff (rst)
    (walk_req_o && walk_ack_i) |=> (resp_valid_o && !resp_hit_o && rdy_o));

  a_r7_miss_stall: assert property (@(posedge clk) disable iff (rst)
    (resp_valid_o && !resp_hit_o) |-> (resp_stall_o == 2'd1 || resp_stall_o == 2'd2));

  a_r2_hit_no_stall: assert property (@(posedge clk) disable iff (rst)
    (resp_valid_o && resp_hit_o) |-> (resp_stall_o == 2'd0));

  a_r8_flush_then_miss: assert property (@(posedge clk) disable iff (rst)
    flush_i ##1 (req_valid_i && rdy_o && !flush_i) |=> !resp_valid_o);
endmodule

bind fetch_utlb fetch_utlb_chk #(.VA_W(VA_W), .ASID_W(ASID_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .flush_i      (flush_i),
  .req_valid_i  (req_valid_i),
  .rdy_o        (rdy_o),
  .walk_req_o   (walk_req_o),
  .walk_ack_i   (walk_ack_i),
  .walk_vpn_o   (walk_vpn_o),
  .walk_asid_o  (walk_asid_o),
  .resp_valid_o (resp_valid_o),
  .resp_hit_o   (resp_hit_o),
  .resp_stall_o (resp_stall_o)
);

// File: tb/fetch_utlb_tb_top.sv
`timescale 1ns/1ps
module fetch_utlb_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush_i = 1'b0;
  logic req_valid_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic [7:0]  req_asid_i = '0;
  logic req_short_i = 1'b0;
  logic rdy_o, resp_valid_o, resp_hit_o, walk_req_o;
  logic [31:0] resp_paddr_o;
  logic [1:0]  resp_stall_o;
  logic [19:0] walk_vpn_o;
  logic [7:0]  walk_asid_o;
  logic walk_ack_i = 1'b0;
  logic [19:0] walk_ppn_i = '0;
  logic walk_global_i = 1'b0;

  always #2.5 clk = ~clk;

  fetch_utlb dut_i (.*);

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  bit          m_v[2];
  bit          m_g[2];
  logic [19:0] m_vpn[2];
  logic [7:0]  m_asid[2];
  logic [19:0] m_ppn[2];
  bit          m_lru;

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] ppn_of(logic [19:0] vpn, logic [7:0] asid);
    return (vpn * 20'd7) ^ {asid, 12'h0A5};
  endfunction

  function automatic int model_match(logic [19:0] vpn, logic [7:0] asid);
    for (int e = 0; e < 2; e++)
      if (m_v[e] && m_vpn[e] == vpn && (m_g[e] || m_asid[e] == asid)) return e;
    return -1;
  endfunction

  task automatic model_flush();
    m_v[0] = 1'b0;
    m_v[1] = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    model_flush();
  endtask

  // one complete lookup; tag labels the hit/miss decision check
  task automatic lookup(input logic [19:0] vpn, input logic [11:0] off,
                        input logic [7:0] asid, input bit short_c,
                        input bit g, input logic [19:0] ppn,
                        input bit with_flush, input string tag);
    int idx;
    int waitn;
    @(negedge clk);
    req_valid_i = 1'b1;
    req_vaddr_i = {vpn, off};
    req_asid_i  = asid;
    req_short_i = short_c;
    flush_i     = with_flush;
    if (with_flush) model_flush();
    idx = model_match(vpn, asid);
    @(negedge clk);
    req_valid_i = 1'b0;
    flush_i     = 1'b0;
    chk({tag, " hit/miss"}, resp_hit_o, (idx >= 0));
    if (idx >= 0) begin
      chk("R2 resp_valid", resp_valid_o, 1);
      chk("R2 paddr", resp_paddr_o, {m_ppn[idx], off});
      chk("R2 stall", resp_stall_o, 0);
      m_lru = (idx == 0);
    end else begin
      chk("R5 no early resp", resp_valid_o, 0);
      chk("R5 walk_req", walk_req_o, 1);
      chk("R5 walk_vpn", walk_vpn_o, vpn);
      chk("R5 walk_asid", walk_asid_o, asid);
      chk("R5 rdy low", rdy_o, 0);
      waitn = $urandom % 4;
      for (int i = 0; i < waitn; i++) begin
        req_valid_i = $urandom % 2;
        req_vaddr_i = $urandom;
        @(negedge clk);
        chk("R5 busy ignores lookup", resp_valid_o, 0);
        chk("R5 walk held", {walk_req_o, walk_vpn_o}, {1'b1, vpn});
      end
      req_valid_i   = 1'b0;
      walk_ack_i    = 1'b1;
      walk_ppn_i    = ppn;
      walk_global_i = g;
      @(negedge clk);
      walk_ack_i = 1'b0;
      chk("R7 resp_valid", resp_valid_o, 1);
      chk("R7 miss flag", resp_hit_o, 0);
      chk("R7 paddr", resp_paddr_o, {ppn, off});
      chk("R7 stall", resp_stall_o, short_c ? 1 : 2);
      chk("R7 ready again", {rdy_o, walk_req_o}, 2'b10);
      m_v[m_lru] = 1'b1;
      m_vpn[m_lru] = vpn;
      m_asid[m_lru] = asid;
      m_g[m_lru] = g;
      m_ppn[m_lru] = ppn;
      m_lru = ~m_lru;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    logic [19:0] pa_a, pa_b, pa_c;
    void'($urandom(32'd20240611));
    model_flush();
    m_lru = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rdy", rdy_o, 1);
    chk("R1 resp_valid", resp_valid_o, 0);
    chk("R1 walk_req", walk_req_o, 0);
    chk("R1 stall", resp_stall_o, 0);

    pa_a = 20'h0AAAA; pa_b = 20'h0BBBB; pa_c = 20'h0CCCC;
    // R1: empty after reset; fills go to entry 0 then entry 1
    lookup(20'h00100, 12'h123, 8'h01, 1'b0, 1'b0, pa_a, 1'b0, "R1");
    lookup(20'h00200, 12'h456, 8'h01, 1'b1, 1'b0, pa_b, 1'b0, "R6");
    lookup(20'h00100, 12'hFFF, 8'h01, 1'b0, 1'b0, pa_a, 1'b0, "R2");
    // R4: hit on entry 1 points LRU at entry 0, so C evicts A
    lookup(20'h00200, 12'h000, 8'h01, 1'b0, 1'b0, pa_b, 1'b0, "R4");
    lookup(20'h00300, 12'h010, 8'h01, 1'b1, 1'b0, pa_c, 1'b0, "R6");
    lookup(20'h00100, 12'h020, 8'h01, 1'b0, 1'b0, pa_a, 1'b0, "R6");
    lookup(20'h00300, 12'h030, 8'h01, 1'b0, 1'b0, pa_c, 1'b0, "R4");
    // R3: identifier mismatch misses
    lookup(20'h00300, 12'h040, 8'h02, 1'b0, 1'b0, pa_b, 1'b0, "R3");
    // R8: flush, then previously valid page misses
    do_flush();
    lookup(20'h00300, 12'h050, 8'h02, 1'b1, 1'b0, pa_b, 1'b0, "R8");
    lookup(20'h00300, 12'h060, 8'h02, 1'b0, 1'b0, pa_b, 1'b0, "R2");
    lookup(20'h00300, 12'h070, 8'h02, 1'b0, 1'b0, pa_c, 1'b1, "R8");
    // R9: entry 0 non-global id 5, entry 1 global, same page
    do_flush();
    m_lru = 1'b0;
    while (m_lru != 1'b0) begin end
    lookup(20'h00400, 12'h001, 8'h05, 1'b0, 1'b0, 20'h11111, 1'b0, "R9");
    lookup(20'h00400, 12'h002, 8'h06, 1'b0, 1'b1, 20'h22222, 1'b0, "R3");
    lookup(20'h00400, 12'h003, 8'h05, 1'b0, 1'b0, 20'h0, 1'b0, "R9");
    lookup(20'h00400, 12'h004, 8'h09, 1'b1, 1'b0, 20'h0, 1'b0, "R3");

    for (int n = 0; n < 400; n++) begin
      logic [19:0] v;
      logic [7:0]  a;
      v = 20'h00010 + 20'($urandom % 5);
      a = 8'($urandom % 3);
      if ($urandom % 40 == 0) do_flush();
      lookup(v, 12'($urandom), a, 1'($urandom), (v[1:0] == 2'b11),
             ppn_of(v, a), ($urandom % 50 == 0), "R3");
    end
    summary();
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
      $finish;
    end
  end
endmodule